// File: doc/BRIEF.md
# Debug Link Host Command Sequencer

This block is the host side of a 17-bit synchronous serial debug link into a processor core. A single-cycle `start` hands it one operation. The operation is a read or write of a core register, a read or write of a system register, or a memory read or write of a byte, word or long. The block turns the operation into an opcode word and its extension words. It shifts each word out MSB first on a debug clock that it generates itself, and shifts in the 17-bit word the target returns at the same time.

The target's answer to a word arrives during the next word. Once the last command word has gone out, the sequencer sends no-operation words (0x0000) to collect the results. It reads each result's top bit and payload. A not-ready answer makes it poll again, up to a programmable limit. A bus-error answer, an illegal-command answer or too many polls end the command with an error code. Valid data is assembled into a 32-bit result. The end of every command is marked by a one-cycle `done`, with `rspData` and `rspErr` held until the next command ends.

Top module: `dbg_seq_host`

## Requirements
- R1: Every word on the link is 17 debug-clock periods long, sent MSB first with bit 16 at 0. `dsDi` changes only while `dsClk` is low, and the target's `dsDo` is sampled at the end of each low phase.
- R2: Each high phase and each low phase of `dsClk` inside a word lasts `clkDiv`+1 system cycles, so `clkDiv`=0 gives half the system clock rate.
- R3: Register operations send opcode 0x2180|r for a read and 0x2080|r for a write, with r = `cmdReg` (0–7 data, 8–15 address registers). With `cmdSys`=1 the opcodes become 0x2580|r and 0x2480|r. A write follows the opcode with the high data word, then the low data word.
- R4: Memory operations send 0x1900|tt for a read and 0x1800|tt for a write. tt is 0x00 for `cmdSize`=0 (byte), 0x40 for 1 (word) and 0x80 for 2 or 3 (long). The opcode is followed by the address high word, then the address low word. A write then sends one data word, or the high word then the low word for a long. A byte travels as {8'h00, data[7:0]}.
- R5: After the last command word, each further word sent is the no-operation word 0x0000. A register read or a long memory read takes two data replies, high half first.
- R6: A read that ends without error returns `rspErr`=0. A byte read is zero-extended from bits 7:0 of the reply, a word read is zero-extended from its 16 bits, and a long or register read gives the full 32 bits.
- R7: A write ends with `rspErr`=0 on its first reply with bit 16 at 0 (the completion status 0x0FFFF).
- R8: A reply of 0x10000 (not ready) makes the block send another 0x0000 word. Up to `pollLimit` consecutive not-ready replies are tolerated.
- R9: The (`pollLimit`+1)-th consecutive not-ready reply ends the command with `rspErr`=3 and `rspData`=0, with no further word sent.
- R10: A reply of 0x10001 (bus error) ends the command with `rspErr`=1 and `rspData`=0.
- R11: A reply of 0x1FFFF, or any other reply with bit 16 set that is neither not-ready nor bus error, ends the command with `rspErr`=2 and `rspData`=0.
- R12: `start` is taken only while `busy` is low. `busy` stays high until the end, `done` is high for exactly one cycle with `busy` low, and a `start` pulse while busy sends nothing.
- R13: After reset `busy`, `done`, `dsClk` and `dsDi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command launch, taken while idle |
| cmdOp | input | 2 | 0 register read, 1 register write, 2 memory read, 3 memory write |
| cmdSys | input | 1 | Register operations address the system register group |
| cmdReg | input | 4 | Register index |
| cmdSize | input | 2 | Memory size: 0 byte, 1 word, 2/3 long |
| cmdAddr | input | 32 | Memory address |
| cmdData | input | 32 | Write data |
| clkDiv | input | DIV_W | Debug clock half-period minus one, in system cycles |
| pollLimit | input | POLL_W | Consecutive not-ready replies tolerated |
| dsDo | input | 1 | Serial reply bit from target |
| dsClk | output | 1 | Debug serial clock |
| dsDi | output | 1 | Serial command bit to target |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rspData | output | 32 | Read result (0 on error or write) |
| rspErr | output | 2 | 0 ok, 1 bus error, 2 illegal, 3 poll timeout |

## Verification
All sixteen register indices in both register groups are read at the fastest clock rate and written, then read back, at a slower one. This separates the opcode and index encoding from the order of the data halves. Memory writes and reads sweep the three sizes over unaligned and wrapping addresses with data whose upper bytes are non-zero, which exposes wrong tt codes, wrong byte packing and missing zero extension. The not-ready count is placed just below, at, and beyond the poll limit, including a limit of zero, so that an off-by-one in the abort shows up in the number of polling words the target model counts. Injected bus-error and illegal replies, plus a second `start` issued mid-command, cover the remaining exits.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

  localparam int LINK_BITS = 17;
  localparam logic [15:0] NOP_WORD = 16'h0000;

  typedef enum logic [1:0] {OP_REG_RD, OP_REG_WR, OP_MEM_RD, OP_MEM_WR} opKind_t;
  typedef enum logic [1:0] {SZ_BYTE, SZ_WORD, SZ_LONG, SZ_LONG2} xferSize_t;
  typedef enum logic [1:0] {ERR_NONE, ERR_BUS, ERR_ILLEGAL, ERR_TIMEOUT} errCode_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SEND, ST_RESULT} seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic        startWord;
    logic [15:0] txWord;
  } linkStrobe_t;

endpackage

// File: rtl/dbg_link_shift.sv
module dbg_link_shift
  import dbgseq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  linkStrobe_t          strb,
  input  logic [DIV_W-1:0]     clkDiv,
  input  logic                 dsDo,
  output logic                 dsClk,
  output logic                 dsDi,
  output logic                 wordDone,
  output logic [LINK_BITS-1:0] rxFrame
);

  localparam int BIT_W = $clog2(LINK_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(LINK_BITS - 1);

  logic                 active;
  logic                 phaseHi;
  logic [DIV_W-1:0]     divCnt;
  logic [BIT_W-1:0]     bitCnt;
  logic [LINK_BITS-1:0] txSh;
  logic [LINK_BITS-1:0] rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      phaseHi  <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      wordDone <= 1'b0;
    end else begin
      wordDone <= 1'b0;
      if (strb.startWord) begin
        active  <= 1'b1;
        phaseHi <= 1'b0;
        divCnt  <= '0;
        bitCnt  <= '0;
        txSh    <= {1'b0, strb.txWord};
      end else if (active) begin
        if (divCnt == clkDiv) begin
          divCnt <= '0;
          if (!phaseHi) begin
            // end of low phase: capture reply bit, raise clock
            rxSh    <= {rxSh[LINK_BITS-2:0], dsDo};
            phaseHi <= 1'b1;
          end else begin
            phaseHi <= 1'b0;
            txSh    <= {txSh[LINK_BITS-2:0], 1'b0};
            if (bitCnt == LAST_BIT) begin
              active   <= 1'b0;
              wordDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign dsClk   = phaseHi;
  assign dsDi    = txSh[LINK_BITS-1];
  assign rxFrame = rxSh;

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.startWord |-> !active) else $error("word started mid-word"); // R1
  AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (dsClk && $past(dsClk)) |-> $stable(dsDi)) else $error("dsDi moved while clock high"); // R1
  AST_WORD_ENDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |-> !dsClk) else $error("word ended with clock high"); // R1
  AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !dsClk) else $error("clock high while idle"); // R13

endmodule

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbgseq_pkg::*;
#(
  parameter int POLL_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [1:0]           cmdOp,
  input  logic                 cmdSys,
  input  logic [3:0]           cmdReg,
  input  logic [1:0]           cmdSize,
  input  logic [31:0]          cmdAddr,
  input  logic [31:0]          cmdData,
  input  logic [POLL_W-1:0]    pollLimit,
  input  logic                 wordDone,
  input  logic [LINK_BITS-1:0] rxFrame,
  output linkStrobe_t          strb,
  output logic                 busy,
  output logic                 done,
  output logic [31:0]          rspData,
  output logic [1:0]           rspErr
);

  seqState_t         state;
  opKind_t           opQ;
  xferSize_t         sizeQ;
  logic              sysQ;
  logic [3:0]        regQ;
  logic [31:0]       addrQ;
  logic [31:0]       dataQ;
  logic [2:0]        idx;
  logic              resIdx;
  logic [POLL_W-1:0] nrCnt;
  logic [15:0]       acc;
  logic [31:0]       rspDataQ;
  errCode_t          errQ;
  logic              doneQ;

  // command decode
  logic        isLong, isRead, twoRes;
  logic [7:0]  tt;
  logic [15:0] opcode;
  logic [2:0]  lastCmd;

  always_comb begin
    isLong = (sizeQ == SZ_LONG) || (sizeQ == SZ_LONG2);
    isRead = (opQ == OP_REG_RD) || (opQ == OP_MEM_RD);
    twoRes = (opQ == OP_REG_RD) || ((opQ == OP_MEM_RD) && isLong);
    case (sizeQ)
      SZ_BYTE: tt = 8'h00;
      SZ_WORD: tt = 8'h40;
      default: tt = 8'h80;
    endcase
    case (opQ)
      OP_REG_RD: opcode = {(sysQ ? 8'h25 : 8'h21), 4'h8, regQ};
      OP_REG_WR: opcode = {(sysQ ? 8'h24 : 8'h20), 4'h8, regQ};
      OP_MEM_RD: opcode = {8'h19, tt};
      default:   opcode = {8'h18, tt};
    endcase
    case (opQ)
      OP_REG_RD: lastCmd = 3'd0;
      OP_REG_WR: lastCmd = 3'd2;
      OP_MEM_RD: lastCmd = 3'd2;
      default:   lastCmd = isLong ? 3'd4 : 3'd3;
    endcase
  end

  // reply classification
  logic rxNotReady, rxBusErr, rxError;
  logic launch, sendMore, enterRes, polling, dataMore, finish;

  always_comb begin
    rxNotReady = rxFrame[16] && (rxFrame[15:0] == 16'h0000);
    rxBusErr   = rxFrame[16] && (rxFrame[15:0] == 16'h0001);
    rxError    = rxFrame[16];
    launch     = (state == ST_LOAD);
    sendMore   = (state == ST_SEND) && wordDone && (idx != lastCmd);
    enterRes   = (state == ST_SEND) && wordDone && (idx == lastCmd);
    polling    = (state == ST_RESULT) && wordDone && rxNotReady && (nrCnt != pollLimit);
    dataMore   = (state == ST_RESULT) && wordDone && !rxError && isRead && twoRes && !resIdx;
    finish     = (state == ST_RESULT) && wordDone && !polling && !dataMore;
  end

  // next outgoing word
  logic [2:0]  wordSel;
  logic [15:0] cmdWord;

  always_comb begin
    wordSel = launch ? 3'd0 : (idx + 3'd1);
    case (wordSel)
      3'd0:    cmdWord = opcode;
      3'd1:    cmdWord = (opQ == OP_REG_WR) ? dataQ[31:16] : addrQ[31:16];
      3'd2:    cmdWord = (opQ == OP_REG_WR) ? dataQ[15:0] : addrQ[15:0];
      3'd3:    cmdWord = isLong ? dataQ[31:16]
                        : ((sizeQ == SZ_BYTE) ? {8'h00, dataQ[7:0]} : dataQ[15:0]);
      default: cmdWord = dataQ[15:0];
    endcase
    strb.startWord = launch || sendMore || enterRes || polling || dataMore;
    strb.txWord    = (launch || sendMore) ? cmdWord : NOP_WORD;
  end

  // result on completion
  errCode_t    finErr;
  logic [31:0] finData;

  always_comb begin
    if (rxNotReady)    finErr = ERR_TIMEOUT;
    else if (rxBusErr) finErr = ERR_BUS;
    else if (rxError)  finErr = ERR_ILLEGAL;
    else               finErr = ERR_NONE;
    if (rxError || !isRead)   finData = '0;
    else if (twoRes)          finData = {acc, rxFrame[15:0]};
    else if (sizeQ == SZ_BYTE) finData = {24'h0, rxFrame[7:0]};
    else                      finData = {16'h0, rxFrame[15:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      opQ      <= OP_REG_RD;
      sizeQ    <= SZ_BYTE;
      sysQ     <= 1'b0;
      regQ     <= '0;
      addrQ    <= '0;
      dataQ    <= '0;
      idx      <= '0;
      resIdx   <= 1'b0;
      nrCnt    <= '0;
      acc      <= '0;
      rspDataQ <= '0;
      errQ     <= ERR_NONE;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          opQ   <= opKind_t'(cmdOp);
          sizeQ <= xferSize_t'(cmdSize);
          sysQ  <= cmdSys;
          regQ  <= cmdReg;
          addrQ <= cmdAddr;
          dataQ <= cmdData;
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          idx   <= '0;
          state <= ST_SEND;
        end
        ST_SEND: if (wordDone) begin
          if (idx == lastCmd) begin
            state  <= ST_RESULT;
            resIdx <= 1'b0;
            nrCnt  <= '0;
          end else begin
            idx <= idx + 3'd1;
          end
        end
        ST_RESULT: if (wordDone) begin
          if (polling) begin
            nrCnt <= nrCnt + 1'b1;
          end else if (dataMore) begin
            acc    <= rxFrame[15:0];
            resIdx <= 1'b1;
            nrCnt  <= '0;
          end else begin
            rspDataQ <= finData;
            errQ     <= finErr;
            doneQ    <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;
  assign rspData = rspDataQ;
  assign rspErr  = errQ;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R12
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy) else $error("done while busy"); // R12
  AST_WORD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.startWord |-> busy) else $error("word sent while idle"); // R12
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (done && (rspErr != 2'd0)) |-> (rspData == 32'h0)) else $error("data on error"); // R10
  AST_FINISH_ON_WORD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(wordDone)) else $error("finished without a reply"); // R9

endmodule

// File: rtl/dbg_seq_host.sv
module dbg_seq_host
  import dbgseq_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        cmdOp,
  input  logic              cmdSys,
  input  logic [3:0]        cmdReg,
  input  logic [1:0]        cmdSize,
  input  logic [31:0]       cmdAddr,
  input  logic [31:0]       cmdData,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic              dsDo,
  output logic              dsClk,
  output logic              dsDi,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rspData,
  output logic [1:0]        rspErr
);

  linkStrobe_t          strb;
  logic                 wordDone;
  logic [LINK_BITS-1:0] rxFrame;

  dbg_seq_ctrl #(.POLL_W(POLL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdOp(cmdOp), .cmdSys(cmdSys),
    .cmdReg(cmdReg), .cmdSize(cmdSize), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .pollLimit(pollLimit), .wordDone(wordDone), .rxFrame(rxFrame), .strb(strb),
    .busy(busy), .done(done), .rspData(rspData), .rspErr(rspErr)
  );

  dbg_link_shift #(.DIV_W(DIV_W)) u_link (
    .clk(clk), .rstN(rstN), .strb(strb), .clkDiv(clkDiv), .dsDo(dsDo),
    .dsClk(dsClk), .dsDi(dsDi), .wordDone(wordDone), .rxFrame(rxFrame)
  );

endmodule

// File: tb/dbg_seq_host_tb.sv
module dbg_seq_host_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic        cmdSys = 1'b0;
  logic [3:0]  cmdReg = '0;
  logic [1:0]  cmdSize = '0;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic [7:0]  clkDiv = '0;
  logic [7:0]  pollLimit = 8'd4;
  logic        dsClk, dsDi, dsDo, busy, done;
  logic [31:0] rspData;
  logic [1:0]  rspErr;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  dbg_seq_host u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdOp(cmdOp), .cmdSys(cmdSys),
    .cmdReg(cmdReg), .cmdSize(cmdSize), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .clkDiv(clkDiv), .pollLimit(pollLimit), .dsDo(dsDo), .dsClk(dsClk),
    .dsDi(dsDi), .busy(busy), .done(done), .rspData(rspData), .rspErr(rspErr)
  );

  // ---------------- target model ----------------
  logic [16:0] outSh = 17'h10000;
  logic [16:0] inSh = '0;
  int          bitN = 0;
  logic [31:0] tRegs [0:15];
  logic [31:0] tSys  [0:15];
  logic [7:0]  tMem  [0:63];
  logic [15:0] opW = '0;
  logic [15:0] ext [0:4];
  int          extNeed = 0, extGot = 0;
  bit          inCmd = 0;
  logic [16:0] rq [0:15];
  int          rqN = 0, rqP = 0;
  int          injNr = 0, injErr = 0;
  int          nopCount = 0, badFrames = 0, opCount = 0, unknownOps = 0;

  assign dsDo = outSh[16];

  function automatic int mi(input logic [31:0] a, input int k);
    return (int'(a[5:0]) + k) & 63;
  endfunction

  task automatic pushRq(input logic [16:0] v);
    rq[rqN] = v;
    rqN++;
  endtask

  task automatic execute();
    logic [31:0] a;
    int r;
    inCmd = 0;
    rqN = 0;
    rqP = 0;
    a = {ext[0], ext[1]};
    r = int'(opW[3:0]);
    for (int i = 0; i < injNr; i++) pushRq(17'h10000);
    if (injErr == 1) pushRq(17'h10001);
    else if (injErr == 2) pushRq(17'h1FFFF);
    else begin
      case (opW[15:8])
        8'h21: begin pushRq({1'b0, tRegs[r][31:16]}); pushRq({1'b0, tRegs[r][15:0]}); end
        8'h25: begin pushRq({1'b0, tSys[r][31:16]});  pushRq({1'b0, tSys[r][15:0]});  end
        8'h20: begin tRegs[r] = {ext[0], ext[1]}; pushRq(17'h0FFFF); end
        8'h24: begin tSys[r]  = {ext[0], ext[1]}; pushRq(17'h0FFFF); end
        8'h19: begin
          if (opW[7:0] == 8'h00) pushRq({9'h0, tMem[mi(a,0)]});
          else if (opW[7:0] == 8'h40) pushRq({1'b0, tMem[mi(a,0)], tMem[mi(a,1)]});
          else begin
            pushRq({1'b0, tMem[mi(a,0)], tMem[mi(a,1)]});
            pushRq({1'b0, tMem[mi(a,2)], tMem[mi(a,3)]});
          end
        end
        8'h18: begin
          if (opW[7:0] == 8'h00) tMem[mi(a,0)] = ext[2][7:0];
          else if (opW[7:0] == 8'h40) begin
            tMem[mi(a,0)] = ext[2][15:8]; tMem[mi(a,1)] = ext[2][7:0];
          end else begin
            tMem[mi(a,0)] = ext[2][15:8]; tMem[mi(a,1)] = ext[2][7:0];
            tMem[mi(a,2)] = ext[3][15:8]; tMem[mi(a,3)] = ext[3][7:0];
          end
          pushRq(17'h0FFFF);
        end
        default: pushRq(17'h1FFFF);
      endcase
    end
    outSh = rq[0];
    rqP = 1;
  endtask

  task automatic handleWord(input logic [16:0] w);
    if (w[16]) badFrames++;
    if (inCmd) begin
      ext[extGot] = w[15:0];
      extGot++;
      outSh = 17'h10000;
      if (extGot == extNeed) execute();
    end else if (w[15:0] == 16'h0000) begin
      nopCount++;
      if (rqP < rqN) begin outSh = rq[rqP]; rqP++; end
      else outSh = 17'h10000;
    end else begin
      opW = w[15:0];
      opCount++;
      extGot = 0;
      case (w[15:8])
        8'h21, 8'h25: extNeed = 0;
        8'h20, 8'h24, 8'h19: extNeed = 2;
        8'h18: extNeed = (w[7:0] == 8'h80) ? 4 : 3;
        default: begin extNeed = 0; unknownOps++; end
      endcase
      if (extNeed == 0) execute();
      else begin inCmd = 1; outSh = 17'h10000; end
    end
  endtask

  always @(posedge dsClk) begin : tgtShift
    logic [16:0] w;
    w = {inSh[15:0], dsDi};
    if (bitN == 16) begin
      bitN = 0;
      inSh = '0;
      handleWord(w);
    end else begin
      inSh = w;
      bitN++;
      outSh = {outSh[15:0], 1'b0};
    end
  end

  // ---------------- clock phase monitor ----------------
  int hiRun = 0, loRun = 0, lastHi = 0, minLo = 1000;
  always @(negedge clk) begin
    if (dsClk) begin
      hiRun++;
      if (loRun != 0 && loRun < minLo) minLo = loRun;
      loRun = 0;
    end else begin
      if (hiRun != 0) lastHi = hiRun;
      hiRun = 0;
      if (busy) loRun++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic [1:0] op, input logic s, input logic [3:0] r,
                        input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic [1:0] re);
    @(negedge clk);
    cmdOp = op; cmdSys = s; cmdReg = r; cmdSize = sz; cmdAddr = a; cmdData = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    rd = rspData;
    re = rspErr;
  endtask

  function automatic logic [7:0] ttOf(input logic [1:0] sz);
    return (sz == 2'd0) ? 8'h00 : (sz == 2'd1) ? 8'h40 : 8'h80;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] rd, d, a, expD;
    logic [1:0]  re;
    for (int i = 0; i < 16; i++) begin
      tRegs[i] = 32'hC0DE0000 | (i * 32'h111);
      tSys[i]  = 32'h5A5A0000 ^ (i << 4);
    end
    for (int i = 0; i < 64; i++) tMem[i] = 8'(i * 7);

    repeat (3) @(negedge clk);
    // R13 reset state
    check(busy == 1'b0, "R13 busy", {31'h0, busy}, 32'h0);
    check(done == 1'b0, "R13 done", {31'h0, done}, 32'h0);
    check(dsClk == 1'b0, "R13 dsClk", {31'h0, dsClk}, 32'h0);
    check(dsDi == 1'b0, "R13 dsDi", {31'h0, dsDi}, 32'h0);
    rstN = 1'b1;

    // R3/R5/R6 register reads, both groups, fastest clock
    clkDiv = 8'd0;
    for (int s = 0; s < 2; s++) begin
      for (int r = 0; r < 16; r++) begin
        runCmd(2'd0, s[0], 4'(r), 2'd0, 32'h0, 32'h0, rd, re);
        expD = s ? (32'h5A5A0000 ^ (r << 4)) : (32'hC0DE0000 | (r * 32'h111));
        check(rd == expD && re == 2'd0, "R6 register read data", rd, expD);
        check(opW == ((s ? 16'h2580 : 16'h2180) | 16'(r)), "R3 read opcode", {16'h0, opW},
              {16'h0, (s ? 16'h2580 : 16'h2180) | 16'(r)});
      end
    end
    check(lastHi == 1, "R2 high phase div0", lastHi, 1);
    check(minLo == 1, "R2 low phase div0", minLo, 1);

    // R3/R7 register writes then read back, slower clock
    clkDiv = 8'd2;
    minLo = 1000;
    for (int r = 0; r < 16; r++) begin
      d = (r * 32'h01020304) ^ 32'hF00F1234;
      runCmd(2'd1, r[0], 4'(r), 2'd0, 32'h0, d, rd, re);
      check(re == 2'd0 && rd == 32'h0, "R7 write completion", {30'h0, re}, 32'h0);
      check(opW == ((r[0] ? 16'h2480 : 16'h2080) | 16'(r)), "R3 write opcode", {16'h0, opW},
            {16'h0, (r[0] ? 16'h2480 : 16'h2080) | 16'(r)});
      check(ext[0] == d[31:16] && ext[1] == d[15:0], "R3 write data order",
            {ext[0], ext[1]}, d);
      runCmd(2'd0, r[0], 4'(r), 2'd0, 32'h0, 32'h0, rd, re);
      check(rd == d, "R5 read back", rd, d);
    end
    check(lastHi == 3, "R2 high phase div2", lastHi, 3);
    check(minLo == 3, "R2 low phase div2", minLo, 3);
    check(badFrames == 0, "R1 bit16 clear", badFrames, 0);
    check(unknownOps == 0, "R1 framing", unknownOps, 0);

    // R4/R6 memory sweep
    clkDiv = 8'd1;
    for (int sz = 0; sz < 3; sz++) begin
      for (int k = 0; k < 3; k++) begin
        a = (k == 0) ? 32'h00AB0010 : (k == 1) ? 32'h00AB0021 : 32'h00AB003E;
        d = 32'hDEADBE5A + (sz * 32'h01010101) + k;
        runCmd(2'd3, 1'b0, 4'h0, 2'(sz), a, d, rd, re);
        check(re == 2'd0, "R7 mem write status", {30'h0, re}, 32'h0);
        check(opW == {8'h18, ttOf(2'(sz))}, "R4 write opcode", {16'h0, opW}, {16'h0, 8'h18, ttOf(2'(sz))});
        check(ext[0] == a[31:16] && ext[1] == a[15:0], "R4 address words", {ext[0], ext[1]}, a);
        if (sz == 0) check(ext[2] == {8'h00, d[7:0]}, "R4 byte packing", {16'h0, ext[2]}, {24'h0, d[7:0]});
        else if (sz == 1) check(ext[2] == d[15:0], "R4 word data", {16'h0, ext[2]}, {16'h0, d[15:0]});
        else check(ext[2] == d[31:16] && ext[3] == d[15:0], "R4 long data", {ext[2], ext[3]}, d);
        runCmd(2'd2, 1'b0, 4'h0, 2'(sz), a, 32'h0, rd, re);
        expD = (sz == 0) ? {24'h0, d[7:0]} : (sz == 1) ? {16'h0, d[15:0]} : d;
        check(rd == expD && re == 2'd0, "R6 mem read", rd, expD);
        check(opW == {8'h19, ttOf(2'(sz))}, "R4 read opcode", {16'h0, opW}, {16'h0, 8'h19, ttOf(2'(sz))});
      end
    end

    // R8/R9 polling and timeout
    clkDiv = 8'd0;
    pollLimit = 8'd2;
    injNr = 2; nopCount = 0;
    runCmd(2'd0, 1'b0, 4'd5, 2'd0, 32'h0, 32'h0, rd, re);
    check(rd == tRegs[5] && re == 2'd0, "R8 poll within limit", rd, tRegs[5]);
    check(nopCount == 4, "R8 poll words", nopCount, 4);
    injNr = 3; nopCount = 0;
    runCmd(2'd0, 1'b0, 4'd5, 2'd0, 32'h0, 32'h0, rd, re);
    check(re == 2'd3 && rd == 32'h0, "R9 timeout code", {30'h0, re}, 32'h3);
    check(nopCount == 3, "R9 words before abort", nopCount, 3);
    pollLimit = 8'd0;
    injNr = 1; nopCount = 0;
    runCmd(2'd2, 1'b0, 4'd0, 2'd1, 32'h00AB0010, 32'h0, rd, re);
    check(re == 2'd3 && nopCount == 1, "R9 zero limit", {30'h0, re}, 32'h3);
    injNr = 0;
    runCmd(2'd2, 1'b0, 4'd0, 2'd1, 32'h00AB0010, 32'h0, rd, re);
    check(re == 2'd0, "R8 zero limit no poll", {30'h0, re}, 32'h0);
    pollLimit = 8'd4;
    injNr = 1;
    runCmd(2'd3, 1'b0, 4'd0, 2'd1, 32'h00AB0030, 32'h00001357, rd, re);
    check(re == 2'd0 && tMem[48] == 8'h13 && tMem[49] == 8'h57, "R8 write after not-ready",
          {30'h0, re}, 32'h0);
    injNr = 0;

    // R10/R11 error replies
    injErr = 1;
    runCmd(2'd2, 1'b0, 4'd0, 2'd2, 32'h00AB0004, 32'h0, rd, re);
    check(re == 2'd1 && rd == 32'h0, "R10 bus error", {30'h0, re}, 32'h1);
    injErr = 2;
    runCmd(2'd1, 1'b0, 4'd3, 2'd0, 32'h0, 32'h11112222, rd, re);
    check(re == 2'd2 && rd == 32'h0, "R11 illegal", {30'h0, re}, 32'h2);
    injErr = 0;

    // R12 start ignored while busy
    opCount = 0;
    @(negedge clk);
    cmdOp = 2'd0; cmdSys = 1'b0; cmdReg = 4'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(busy == 1'b1, "R12 busy mid command", {31'h0, busy}, 32'h1);
    cmdOp = 2'd1; cmdReg = 4'd2; cmdData = 32'hBADBAD00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R12 idle at done", {31'h0, busy}, 32'h0);
    check(rspData == tRegs[7], "R12 first command result", rspData, tRegs[7]);
    @(negedge clk);
    check(done == 1'b0, "R12 done one cycle", {31'h0, done}, 32'h0);
    repeat (120) @(negedge clk);
    check(opCount == 1 && busy == 1'b0, "R12 busy start ignored", opCount, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule